// File: doc/BRIEF.md
# Set/Clear Control Register File

This block holds the control bits of an acquisition front end behind a small 32-bit register port. Nothing is changed by read-modify-write. Each control word is split in two halves. A one in the low half asks for the matching control to be set. A one in the high half, sixteen places up, asks for it to be cleared. One write can therefore raise some controls, drop others and leave every control it does not name alone. When both requests for one bit arrive together, the bit toggles, as a J/K flip-flop would.

There are two such words. The general control word holds the indicator, the user output, the trigger-output inversion and the trigger-condition select. Reading it back also returns four live input pins. The acquisition word holds the arm bits for the two sample banks and a 3-bit clock-source field. Reading it back also returns the live busy input.

Three further offsets carry no data. A write to the reset key clears every control. Writes to the start and stop offsets each produce a single-cycle strobe. The read port is combinational on the byte offset.

Top module: `setclr_ctrl_regs`

## Requirements
- R1: After reset every control output is 0, the start and stop strobes are 0, and both words read back with 0 in their control bits.
- R2: A write to the general word (offset 0x00) or the acquisition word (offset 0x04) with low-half bit n at 1 and bit n+16 at 0 sets implemented control n.
- R3: A write with bit n+16 at 1 and bit n at 0 clears implemented control n.
- R4: A write with both bit n and bit n+16 at 1 inverts implemented control n.
- R5: A control whose set and clear bits are both 0 keeps its value. Bit positions that hold no control (general word: all but 0, 1, 4, 5; acquisition word: all but 0, 1, 12, 13, 14) always read back 0.
- R6: Reading the general word returns, in bits 0, 1, 4 and 5, the indicator, the user output, the trigger inversion and the trigger-condition select. It returns the user input pin in bit 16 and the test, reset and sample backplane pins in bits 17, 18 and 19. All other bits read 0.
- R7: In the acquisition word, bank 1 arm is bit 0 and is cleared by bit 16. Bank 2 arm is bit 1 and is cleared by bit 17. On a read, bit 16 returns the busy input and bits 31:17 read 0.
- R8: The clock-source field sits at bits 14:12 of the acquisition word and is cleared by bits 30:28. It drives the clock-select output.
- R9: Any write to the reset key (offset 0x08) clears every control in both words, whatever the data.
- R10: A one-cycle write to offset 0x0C (start) or 0x10 (stop) raises the matching strobe for exactly the next cycle and changes no control.
- R11: Writes to any other offset, and cycles with write enable low, change no control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | 8 | Byte offset for the write and the read |
| wdata | input | 32 | Write data: set requests low, clear requests high |
| rdata | output | 32 | Read-back word for the current offset |
| user_in | input | 1 | Live user input pin |
| bp_test_in | input | 1 | Live backplane test pin |
| bp_reset_in | input | 1 | Live backplane reset pin |
| bp_sample_in | input | 1 | Live backplane sample pin |
| busy_in | input | 1 | Acquisition busy flag |
| led_o | output | 1 | Indicator control |
| uout_o | output | 1 | User output control |
| trig_inv_o | output | 1 | Trigger output inversion |
| trig_cond_o | output | 1 | Trigger condition (1 = armed and started) |
| bank1_arm_o | output | 1 | Sample bank 1 armed |
| bank2_arm_o | output | 1 | Sample bank 2 armed |
| clk_sel_o | output | 3 | Clock-source selection |
| start_o | output | 1 | Start strobe |
| stop_o | output | 1 | Stop strobe |

## Verification
The bench walks every bit position of both words. For each position it starts from both prior states and applies all four set/clear pairings. A design that got the J/K rule wrong would show up here: letting clear win, letting set win, or ignoring a write that carries both requests. Any of these would miss the toggle case. A design that stored unused positions would fail the zero read-back of those bits. Pseudo-random words then mix several controls in one write. A design that applied requests to the wrong half, or disturbed bits it was not asked to touch, would drift from the bench's model. The live pins are swept through all combinations to catch swapped status positions. The reset key, the strobes and unmapped offsets are each followed by a full read-back, so a strobe write that leaked data into a register would be caught.

// File: rtl/setclr_ctrl_regs.sv
module setclr_ctrl_regs #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [DW/2-1:0] CTRL_MASK = 16'h0033,
  parameter logic [DW/2-1:0] ACQ_MASK  = 16'h7003,
  parameter logic [AW-1:0] CTRL_OFS  = 8'h00,
  parameter logic [AW-1:0] ACQ_OFS   = 8'h04,
  parameter logic [AW-1:0] KEY_OFS   = 8'h08,
  parameter logic [AW-1:0] START_OFS = 8'h0C,
  parameter logic [AW-1:0] STOP_OFS  = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          user_in,
  input  logic          bp_test_in,
  input  logic          bp_reset_in,
  input  logic          bp_sample_in,
  input  logic          busy_in,
  output logic          led_o,
  output logic          uout_o,
  output logic          trig_inv_o,
  output logic          trig_cond_o,
  output logic          bank1_arm_o,
  output logic          bank2_arm_o,
  output logic [2:0]    clk_sel_o,
  output logic          start_o,
  output logic          stop_o
);
  localparam int H = DW / 2;
  localparam int CLK_LSB = 12;

  logic [H-1:0] ctrl_q, acq_q;

  function automatic logic [H-1:0] jk_next(input logic [H-1:0] q,
                                           input logic [DW-1:0] w,
                                           input logic [H-1:0] mask);
    return mask & ((w[H-1:0] & ~q) | (~w[DW-1:H] & q));
  endfunction

  wire ctrl_wr  = wr_en && addr == CTRL_OFS;
  wire acq_wr   = wr_en && addr == ACQ_OFS;
  wire key_wr   = wr_en && addr == KEY_OFS;
  wire start_wr = wr_en && addr == START_OFS;
  wire stop_wr  = wr_en && addr == STOP_OFS;

  always_ff @(posedge clk) begin
    if (!rst_n || key_wr) begin
      ctrl_q <= '0;
      acq_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= jk_next(ctrl_q, wdata, CTRL_MASK);
      if (acq_wr)  acq_q  <= jk_next(acq_q, wdata, ACQ_MASK);
    end
    if (!rst_n) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= start_wr;
      stop_o  <= stop_wr;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS)
      rdata = {{(H-4){1'b0}}, bp_sample_in, bp_reset_in, bp_test_in, user_in, ctrl_q};
    else if (addr == ACQ_OFS)
      rdata = {{(H-1){1'b0}}, busy_in, acq_q};
  end

  assign led_o       = ctrl_q[0];
  assign uout_o      = ctrl_q[1];
  assign trig_inv_o  = ctrl_q[4];
  assign trig_cond_o = ctrl_q[5];
  assign bank1_arm_o = acq_q[0];
  assign bank2_arm_o = acq_q[1];
  assign clk_sel_o   = acq_q[CLK_LSB +: 3];
endmodule

// File: rtl/setclr_ctrl_regs_chk.sv
module setclr_ctrl_regs_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_OFS  = 8'h00,
  parameter logic [AW-1:0] ACQ_OFS   = 8'h04,
  parameter logic [AW-1:0] KEY_OFS   = 8'h08,
  parameter logic [AW-1:0] START_OFS = 8'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          led_o,
  input logic          uout_o,
  input logic          trig_inv_o,
  input logic          trig_cond_o,
  input logic          bank1_arm_o,
  input logic          bank2_arm_o,
  input logic [2:0]    clk_sel_o,
  input logic          start_o
);
  wire cw = wr_en && addr == CTRL_OFS;
  wire aw = wr_en && addr == ACQ_OFS;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && wdata[0] && !wdata[16]) |=> led_o);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (aw && wdata[17] && !wdata[1]) |=> !bank2_arm_o);
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && wdata[5] && wdata[21]) |=> trig_cond_o != $past(trig_cond_o));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({led_o, uout_o, trig_inv_o, trig_cond_o,
                        bank1_arm_o, bank2_arm_o, clk_sel_o}));
  p_clkfield_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (aw && wdata[30:28] == 3'b111 && wdata[14:12] == 3'b000) |=> clk_sel_o == 3'b000);
  p_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KEY_OFS) |=> !(led_o || uout_o || trig_inv_o || trig_cond_o ||
                                    bank1_arm_o || bank2_arm_o || |clk_sel_o));
  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(wr_en && addr == START_OFS));
endmodule

bind setclr_ctrl_regs setclr_ctrl_regs_chk #(
  .AW(AW), .DW(DW), .CTRL_OFS(CTRL_OFS), .ACQ_OFS(ACQ_OFS),
  .KEY_OFS(KEY_OFS), .START_OFS(START_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .led_o(led_o), .uout_o(uout_o), .trig_inv_o(trig_inv_o),
  .trig_cond_o(trig_cond_o), .bank1_arm_o(bank1_arm_o),
  .bank2_arm_o(bank2_arm_o), .clk_sel_o(clk_sel_o), .start_o(start_o)
);

// File: tb/setclr_ctrl_regs_bench.sv
module setclr_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CMASK = 16'h0033;
  localparam logic [15:0] AMASK = 16'h7003;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic user_in = 0, bp_test_in = 0, bp_reset_in = 0, bp_sample_in = 0, busy_in = 0;
  logic led_o, uout_o, trig_inv_o, trig_cond_o, bank1_arm_o, bank2_arm_o;
  logic [2:0] clk_sel_o;
  logic start_o, stop_o;

  int n_vec = 0, n_bad = 0;
  logic [15:0] mc = 0, ma = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  setclr_ctrl_regs u_setclr_ctrl_regs (.*);

  function automatic logic [15:0] model_jk(input logic [15:0] q, input logic [31:0] w,
                                           input logic [15:0] m);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      case ({w[i], w[i+16]})
        2'b10: r[i] = 1'b1;
        2'b01: r[i] = 1'b0;
        2'b11: r[i] = ~q[i];
        default: r[i] = q[i];
      endcase
    end
    return r & m;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 8'h00) mc = model_jk(mc, d, CMASK);
    if (a == 8'h04) ma = model_jk(ma, d, AMASK);
    if (a == 8'h08) begin mc = 0; ma = 0; end
  endtask

  task automatic check_all(input string tag);
    addr = 8'h00; #1;
    check(tag, rdata, {12'b0, bp_sample_in, bp_reset_in, bp_test_in, user_in, mc});
    addr = 8'h04; #1;
    check(tag, rdata, {15'b0, busy_in, ma});
    check(tag, {24'b0, led_o, uout_o, trig_inv_o, trig_cond_o, bank1_arm_o, bank2_arm_o, clk_sel_o},
          {24'b0, mc[0], mc[1], mc[4], mc[5], ma[0], ma[1], ma[14:12]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");
    check("R1 strobes", {30'b0, start_o, stop_o}, 32'b0);

    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 16; b++) begin
        for (int init = 0; init < 2; init++) begin
          for (int jk = 0; jk < 4; jk++) begin
            logic [7:0] a = (w == 0) ? 8'h00 : 8'h04;
            wr(a, init ? (32'h1 << b) : (32'h1 << (b + 16)));
            wr(a, (jk[1] ? (32'h1 << b) : 32'h0) | (jk[0] ? (32'h1 << (b + 16)) : 32'h0));
            case (jk)
              0: check_all("R5 hold/unused");
              1: check_all("R3 clear");
              2: check_all("R2 set");
              default: check_all("R4 toggle");
            endcase
          end
        end
      end
    end

    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      wr(i[0] ? 8'h04 : 8'h00, lfsr);
      check_all(i[0] ? "R7 R8 mixed acq" : "R6 mixed ctrl");
    end

    wr(8'h04, 32'h0000_5000);
    check("R8 clk load", {29'b0, clk_sel_o}, 32'd5);
    wr(8'h04, 32'h7000_0000);
    check("R8 clk clear", {29'b0, clk_sel_o}, 32'd0);

    for (int p = 0; p < 32; p++) begin
      {busy_in, bp_sample_in, bp_reset_in, bp_test_in, user_in} = p[4:0];
      @(negedge clk);
      check_all("R6 R7 live pins");
    end

    wr(8'h00, 32'h0000_0033);
    wr(8'h04, 32'h0000_7003);
    check_all("R2 preset");
    wr(8'h08, 32'hA5A5_5A5A);
    check_all("R9 reset key");

    wr(8'h00, 32'h0000_0011);
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R10 start high", {31'b0, start_o}, 32'd1);
    check("R10 stop idle", {31'b0, stop_o}, 32'd0);
    @(negedge clk);
    check("R10 start one cycle", {31'b0, start_o}, 32'd0);
    wr(8'h10, 32'h0000_FFFF);
    check("R10 stop high", {31'b0, stop_o}, 32'd1);
    @(negedge clk);
    check("R10 stop one cycle", {31'b0, stop_o}, 32'd0);
    check_all("R10 no data");

    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h02, 32'h0000_FFFF);
    check_all("R11 other offset");
    addr = 8'h00; wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check_all("R11 wr_en low");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule